// File: doc/BRIEF.md
# Rotating-Parity Stripe Address Mapper

This block turns a logical block number into its physical place in a five-column block-striped array. Every stripe holds four data blocks and one parity block. The parity block moves one column to the left from each stripe to the next. For each request the mapper returns three values: the stripe (row) number, the column that holds the data block, and the column that holds parity for that stripe. All three are registered and appear one cycle after the request strobe.

A second, independent port answers a simpler question: given a stripe number, which column holds its parity. The array controller uses this port when it plans parity updates or rebuilds. Both ports work in the same cycle without affecting each other.

The block has no divider. The stripe number is a shift of the logical index. The residue modulo five comes from a constant-divide nibble fold, which works because sixteen is congruent to one modulo five. The result therefore arrives in a single cycle for any 32-bit index.

Top module: `stripe_mapper`

## Requirements
- R1: The parity column of stripe s is 4 − (s mod 5). Stripe 0 has parity in column 4, stripe 4 in column 0, and stripe 5 in column 4 again.
- R2: The stripe number is the logical index divided by four, which is the index shifted right by two bits.
- R3: Let pos = index mod 4 (the two low bits). The data column is pos when pos is below the parity column, and pos + 1 otherwise. The data column therefore never equals the parity column.
- R4: map_valid_o is high in exactly the cycle after a cycle in which req_valid_i was high. Its stripe and column outputs belong to that request.
- R5: While req_valid_i is low, map_valid_o is low the next cycle. The stripe and column outputs keep their previous values, whatever req_lba_i carries.
- R6: qry_valid_o is high exactly one cycle after qry_valid_i. qry_par_col_o then equals 4 − (stripe mod 5) for the stripe sampled, over the whole 30-bit stripe range.
- R7: During and right after reset, both valid outputs are low and all data outputs are zero.
- R8: A request and a query in the same cycle both produce correct results in the next cycle.
- R9: The full 32-bit index range maps correctly. Index 0xFFFFFFFF maps to stripe 0x3FFFFFFF, parity column 1 and data column 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Mapping request strobe |
| req_lba_i | input | 32 | Logical block index |
| qry_valid_i | input | 1 | Parity query strobe |
| qry_stripe_i | input | 30 | Stripe number to query |
| map_valid_o | output | 1 | Mapping result valid |
| map_stripe_o | output | 30 | Stripe of the mapped block |
| map_col_o | output | 3 | Column holding the data block |
| map_par_col_o | output | 3 | Parity column of that stripe |
| qry_valid_o | output | 1 | Query result valid |
| qry_par_col_o | output | 3 | Parity column of the queried stripe |

## Verification
The assertions assume that the strobes and the index and stripe buses carry known values whenever a strobe is high. They also assume that the strobes are never X after reset. The rotation property is checked only between consecutive stripe numbers other than the wrap to zero, because 2^30 is not a multiple of five. The stimulus changes inputs only on the falling clock edge and always gives the strobes a defined level. It sweeps the first forty indices back to back, covers the top of the index range, and feeds seeded random indices and stripes.

// File: rtl/stripe_map_pkg.sv
package stripe_map_pkg;
  localparam int unsigned NUM_COLS = 5;
  localparam int unsigned COL_W    = 3;
  localparam int unsigned POS_W    = 2;
  localparam int unsigned REM_W    = 3;

  typedef logic [COL_W-1:0] col_t;
  typedef logic [POS_W-1:0] pos_t;
  typedef logic [REM_W-1:0] rem_t;
endpackage

// File: rtl/mod5_fold.sv
// Residue modulo five by nibble folding (16 == 1 mod 5). Valid for W <= 64.
module mod5_fold
  import stripe_map_pkg::*;
#(
  parameter int unsigned W = 30
) (
  input  logic [W-1:0] val_i,
  output rem_t         rem_o
);
  localparam int unsigned NIB   = (W + 3) / 4;
  localparam int unsigned PAD_W = NIB * 4;
  localparam int unsigned SUM_W = 4 + $clog2(NIB + 1);

  logic [PAD_W-1:0] padded;
  logic [SUM_W-1:0] nib_sum;
  logic [5:0]       fold2;
  logic [5:0]       red;

  assign padded = PAD_W'(val_i);

  always_comb begin
    nib_sum = '0;
    for (int i = 0; i < NIB; i++) begin
      nib_sum = nib_sum + SUM_W'(padded[4*i +: 4]);
    end
  end

  assign fold2 = 6'(nib_sum[3:0]) + 6'(nib_sum[SUM_W-1:4]);

  always_comb begin
    red = fold2;
    if (red >= 6'd20) red = red - 6'd20;
    if (red >= 6'd10) red = red - 6'd10;
    if (red >= 6'd5)  red = red - 6'd5;
  end

  assign rem_o = rem_t'(red);
endmodule

// File: rtl/parity_col.sv
module parity_col
  import stripe_map_pkg::*;
(
  input  rem_t rem_i,
  output col_t par_o
);
  assign par_o = col_t'(NUM_COLS - 1) - col_t'(rem_i);
endmodule

// File: rtl/data_col_sel.sv
// Data fills columns left to right, skipping the parity slot.
module data_col_sel
  import stripe_map_pkg::*;
(
  input  pos_t pos_i,
  input  col_t par_i,
  output col_t col_o
);
  col_t pos_ext;
  assign pos_ext = col_t'(pos_i);
  assign col_o   = (pos_ext < par_i) ? pos_ext : pos_ext + col_t'(1);
endmodule

// File: rtl/stripe_mapper.sv
module stripe_mapper
  import stripe_map_pkg::*;
#(
  parameter int unsigned LBA_W = 32,
  localparam int unsigned ST_W = LBA_W - POS_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [LBA_W-1:0] req_lba_i,
  input  logic            qry_valid_i,
  input  logic [ST_W-1:0] qry_stripe_i,
  output logic            map_valid_o,
  output logic [ST_W-1:0] map_stripe_o,
  output col_t            map_col_o,
  output col_t            map_par_col_o,
  output logic            qry_valid_o,
  output col_t            qry_par_col_o
);
  logic [ST_W-1:0] req_stripe;
  pos_t            req_pos;
  rem_t            req_rem, qry_rem;
  col_t            req_par, req_col, qry_par;

  assign req_stripe = req_lba_i[LBA_W-1:POS_W];
  assign req_pos    = req_lba_i[POS_W-1:0];

  mod5_fold #(.W(ST_W)) u_req_mod (.val_i(req_stripe),   .rem_o(req_rem));
  mod5_fold #(.W(ST_W)) u_qry_mod (.val_i(qry_stripe_i), .rem_o(qry_rem));

  parity_col u_req_par (.rem_i(req_rem), .par_o(req_par));
  parity_col u_qry_par (.rem_i(qry_rem), .par_o(qry_par));

  data_col_sel u_col (.pos_i(req_pos), .par_i(req_par), .col_o(req_col));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_valid_o   <= 1'b0;
      map_stripe_o  <= '0;
      map_col_o     <= '0;
      map_par_col_o <= '0;
    end else begin
      map_valid_o <= req_valid_i;
      if (req_valid_i) begin
        map_stripe_o  <= req_stripe;
        map_col_o     <= req_col;
        map_par_col_o <= req_par;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qry_valid_o   <= 1'b0;
      qry_par_col_o <= '0;
    end else begin
      qry_valid_o <= qry_valid_i;
      if (qry_valid_i) qry_par_col_o <= qry_par;
    end
  end

  // R4
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> map_valid_o);

  // R5
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !map_valid_o);

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(map_stripe_o) && $stable(map_col_o) && $stable(map_par_col_o)));

  // R2
  stripe_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (map_stripe_o == $past(req_lba_i[LBA_W-1:POS_W])));

  // R3
  col_not_parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_valid_o |-> (map_col_o != map_par_col_o && map_col_o < col_t'(NUM_COLS)));

  // R1
  parity_rotate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_valid_o && $past(map_valid_o) && map_stripe_o != '0 &&
     map_stripe_o == ST_W'($past(map_stripe_o) + 1'b1))
    |-> (map_par_col_o == (($past(map_par_col_o) == '0) ? col_t'(NUM_COLS - 1)
                                                         : col_t'($past(map_par_col_o) - 1'b1))));

  // R6
  qry_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qry_valid_i |=> (qry_valid_o && qry_par_col_o < col_t'(NUM_COLS)));
endmodule

// File: tb/sim_stripe_mapper.sv
`timescale 1ns/1ps
module sim_stripe_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_lba = '0;
  logic        qry_valid = 1'b0;
  logic [29:0] qry_stripe = '0;
  logic        map_valid, qry_valid_q;
  logic [29:0] map_stripe;
  logic [2:0]  map_col, map_par, qry_par;

  int checks = 0;
  int errors = 0;
  int ref_col [40];
  int ref_stripe [40];

  always #2.5 clk = ~clk;

  stripe_mapper u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_lba_i(req_lba),
    .qry_valid_i(qry_valid), .qry_stripe_i(qry_stripe),
    .map_valid_o(map_valid), .map_stripe_o(map_stripe),
    .map_col_o(map_col), .map_par_col_o(map_par),
    .qry_valid_o(qry_valid_q), .qry_par_col_o(qry_par)
  );

  function automatic int exp_par(longint s);
    return 4 - int'(s % 5);
  endfunction

  function automatic int exp_col(longint lba);
    int pos = int'(lba % 4);
    int p   = exp_par(lba / 4);
    return (pos < p) ? pos : pos + 1;
  endfunction

  task automatic chk(string rq, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  // Drives at the current falling edge, checks at the next one.
  task automatic step(logic [31:0] lba, logic [29:0] qs, int tcol, int tstripe);
    req_valid = 1'b1; req_lba = lba; qry_valid = 1'b1; qry_stripe = qs;
    @(negedge clk);
    chk("R4 map_valid", map_valid, 1);
    chk("R2 stripe", map_stripe, tstripe);
    chk("R3 data col", map_col, tcol);
    chk("R1 parity col", map_par, exp_par(tstripe));
    chk("R8 qry_valid", qry_valid_q, 1);
    chk("R6 qry parity", qry_par, exp_par(longint'(qs)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    logic [2:0]  last_col, last_par;
    logic [29:0] last_stripe;
    int n = 0;
    // Reference layout built by walking stripes and columns
    for (int s = 0; s < 10; s++) begin
      for (int c = 0; c < 5; c++) begin
        if (c != 4 - (s % 5) && n < 40) begin
          ref_col[n] = c; ref_stripe[n] = s; n++;
        end
      end
    end
    seed_dummy = $urandom(32'd2024);

    repeat (3) @(negedge clk);
    // R7
    chk("R7 map_valid", map_valid, 0);
    chk("R7 qry_valid", qry_valid_q, 0);
    chk("R7 map_col", map_col, 0);
    chk("R7 map_stripe", map_stripe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 idle after reset", map_valid, 0);

    // R1 R2 R3 R4: first forty blocks back to back, query stripes 0..39
    for (int i = 0; i < 40; i++) step(32'(i), 30'(i), ref_col[i], ref_stripe[i]);

    // R5: strobe low, index changes, outputs must hold
    last_col = map_col; last_par = map_par; last_stripe = map_stripe;
    req_valid = 1'b0; qry_valid = 1'b0; req_lba = 32'h1234_5677;
    @(negedge clk);
    chk("R5 valid low", map_valid, 0);
    chk("R5 col held", map_col, last_col);
    chk("R5 par held", map_par, last_par);
    chk("R5 stripe held", map_stripe, last_stripe);
    chk("R6 qry valid low", qry_valid_q, 0);

    // R9 corners
    step(32'hFFFF_FFFF, 30'h3FFF_FFFF, 4, 30'h3FFF_FFFF);
    chk("R9 par at top", map_par, 1);
    step(32'hFFFF_FFFC, 30'h3FFF_FFFE, exp_col(64'hFFFF_FFFC), 30'h3FFF_FFFF);
    step(32'd20, 30'd5, 0, 5);
    chk("R1 stripe5 parity", map_par, 4);
    step(32'd19, 30'd4, 4, 4);
    chk("R1 stripe4 parity", map_par, 0);

    // Random indices and stripes
    for (int k = 0; k < 400; k++) begin
      logic [31:0] l = $urandom;
      logic [29:0] q = 30'($urandom);
      step(l, q, exp_col(longint'(l)), int'(l >> 2));
    end

    req_valid = 1'b0; qry_valid = 1'b0;
    @(negedge clk);
    chk("R5 final valid low", map_valid, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule